// File: doc/BRIEF.md
# Triangle Down-Spread Divider Profile Generator

This block sweeps the effective feedback divide ratio of a clock synthesizer along a symmetric triangle. The triangle lies entirely at or below the programmed nominal divide value, so the synthesized frequency is only ever pulled downward. It is clocked by the synthesizer's reference clock. Its output is a fixed-point divide value, with an integer part and a 16-bit fraction, for the fractional feedback path that follows it. That path is not part of this block.

One sweep lasts 512 reference cycles. A sweep starts at the bottom of the triangle, at nominal minus the spread depth. It climbs in equal steps to exactly the nominal value at the midpoint, then descends in equal steps. The spread depth is M·δ, where δ = SPREAD_Q16/65536. The default of 328 gives δ ≈ 0.5005%. Values up to 393 keep the depth within 0.6%.

The nominal value is taken in only at sweep boundaries. Clearing the enable lets the current sweep finish before the output settles back to the nominal value. While spreading is off, the output simply follows the nominal input.

Top module: `spread_tri_gen`

## Requirements
- R1: While reset is held, and after its release until the first clock edge, div_int equals DEF_M (default 192), div_frac is 0, and no sweep is running.
- R2: While no sweep is running, each clock edge captures nom_m, and the output after that edge is nom_m with a zero fraction.
- R3: A sweep starts on the first edge at which spread_en is high and no sweep is running. The output after that edge is the bottom value M − M·δ, with δ = SPREAD_Q16/65536. This edge is sweep position p = 0.
- R4: At positions p = 0 to 255, the exact value is M·2^24 − M·SPREAD_Q16·(256 − p) in units of 2^-24. div_int is bits 24 and up of that value, and div_frac is bits 23:8.
- R5: At p = 256 the output equals exactly M.0, and it is never above M at any time.
- R6: At positions p = 257 to 511, the exact value is M·2^24 − M·SPREAD_Q16·(p − 256). The sweep is 512 edges long, and the edge after p = 511 is p = 0 of the next sweep.
- R7: While sweeping, the output never falls below M·(1 − 0.006).
- R8: A change on nom_m while a sweep runs has no effect on the output until the edge that follows p = 511.
- R9: If spread_en is low at the edge after p = 511, the sweep stops. From that edge on, the output is the newly captured nom_m with a zero fraction. Before that edge, a low spread_en does not alter the running sweep.
- R10: If spread_en is high at the edge after p = 511, the new sweep's bottom value and its step both use the nom_m captured at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spread_en | input | 1 | Spreading enable |
| nom_m | input | M_W (9) | Nominal feedback divide value |
| div_int | output | M_W (9) | Integer part of the effective divide value |
| div_frac | output | FRAC_W (16) | Fractional part of the effective divide value |

## Verification
At the sweep boundary, the capture of a new nominal value and the enable decision happen on the same edge. The new sweep's reload depth must come from the value being captured, not from the one it replaces. The bench moves nom_m at exactly that boundary edge, both with the enable held high and with it dropped. It then compares the bottom value and every later step against a position-based formula. The bench also changes nom_m and drops the enable in the middle of a sweep, to show that neither acts before the boundary.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic {
    SSM_IDLE  = 1'b0,
    SSM_SWEEP = 1'b1
  } ssm_state_e;

  // per-cycle ramp increment, in 2^-(FRAC_W+HALF_W) units
  function automatic logic [63:0] ssm_step(input logic [63:0] m, input logic [63:0] q16);
    return m * q16;
  endfunction

  // full spread depth: one step for each of the half-sweep positions
  function automatic logic [63:0] ssm_span(input logic [63:0] m, input logic [63:0] q16,
                                           input int half_w);
    return (m * q16) << half_w;
  endfunction

endpackage

// File: rtl/ssm_phase_ctl.sv
module ssm_phase_ctl
  import ssm_pkg::*;
#(
  parameter int PHASE_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spread_en,
  output logic               running,
  output logic [PHASE_W-1:0] phase,
  output logic               wrap,
  output logic               start,
  output logic               rising
);
  localparam logic [PHASE_W-1:0] LAST_POS = '1;

  ssm_state_e state;

  assign running = (state == SSM_SWEEP);
  assign wrap    = running && (phase == LAST_POS);
  assign start   = spread_en && (!running || wrap);
  assign rising  = ~phase[PHASE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SSM_IDLE;
      phase <= '0;
    end else if (start) begin
      state <= SSM_SWEEP;
      phase <= '0;
    end else if (wrap) begin
      state <= SSM_IDLE;
      phase <= '0;
    end else if (running) begin
      phase <= phase + PHASE_W'(1);
    end
  end
endmodule

// File: rtl/ssm_nominal_latch.sv
module ssm_nominal_latch #(
  parameter int M_W   = 9,
  parameter int DEF_M = 192
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic [M_W-1:0] nom_m,
  output logic [M_W-1:0] m_lat
);
  always_ff @(posedge clk) begin
    if (!rst_n)       m_lat <= M_W'(DEF_M);
    else if (capture) m_lat <= nom_m;
  end
endmodule

// File: rtl/ssm_offset_ramp.sv
module ssm_offset_ramp
  import ssm_pkg::*;
#(
  parameter int M_W        = 9,
  parameter int SPREAD_Q16 = 328,
  parameter int HALF_W     = 8,
  parameter int OFF_W      = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold_zero,
  input  logic             rising,
  input  logic [M_W-1:0]   nom_m,
  input  logic [M_W-1:0]   m_lat,
  output logic [OFF_W-1:0] offset
);
  logic [OFF_W-1:0] step, span, reload, next_dn, next_up, sum;

  assign step    = OFF_W'(ssm_step(64'(m_lat), 64'(SPREAD_Q16)));
  assign span    = OFF_W'(ssm_span(64'(m_lat), 64'(SPREAD_Q16), HALF_W));
  assign reload  = OFF_W'(ssm_span(64'(nom_m), 64'(SPREAD_Q16), HALF_W));
  assign sum     = offset + step;
  // saturate at both ends of the triangle
  assign next_dn = (offset > step) ? (offset - step) : '0;
  assign next_up = (sum > span) ? span : sum;

  always_ff @(posedge clk) begin
    if (!rst_n)         offset <= '0;
    else if (start)     offset <= reload;
    else if (hold_zero) offset <= '0;
    else if (rising)    offset <= next_dn;
    else                offset <= next_up;
  end
endmodule

// File: rtl/spread_tri_gen.sv
module spread_tri_gen #(
  parameter int M_W        = 9,
  parameter int FRAC_W     = 16,
  parameter int PHASE_W    = 9,
  parameter int SPREAD_Q16 = 328,
  parameter int DEF_M      = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spread_en,
  input  logic [M_W-1:0]    nom_m,
  output logic [M_W-1:0]    div_int,
  output logic [FRAC_W-1:0] div_frac
);
  localparam int HALF_W = PHASE_W - 1;
  localparam int FI_W   = FRAC_W + HALF_W;
  localparam int OFF_W  = M_W + FI_W + 1;
  localparam int OUT_W  = M_W + FRAC_W;

  logic               running, wrap, start, rising, capture;
  logic [PHASE_W-1:0] phase;
  logic [M_W-1:0]     m_lat;
  logic [OFF_W-1:0]   offset;
  logic [OUT_W-1:0]   out_q;

  ssm_phase_ctl #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .spread_en(spread_en),
    .running(running), .phase(phase), .wrap(wrap),
    .start(start), .rising(rising)
  );

  assign capture = !running || wrap;

  ssm_nominal_latch #(.M_W(M_W), .DEF_M(DEF_M)) u_nom (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .nom_m(nom_m), .m_lat(m_lat)
  );

  ssm_offset_ramp #(
    .M_W(M_W), .SPREAD_Q16(SPREAD_Q16), .HALF_W(HALF_W), .OFF_W(OFF_W)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .start(start), .hold_zero(capture && !start),
    .rising(rising), .nom_m(nom_m), .m_lat(m_lat), .offset(offset)
  );

  // nominal minus offset, dropping the extra ramp resolution bits
  assign out_q    = OUT_W'(({1'b0, m_lat, {FI_W{1'b0}}} - offset) >> HALF_W);
  assign div_int  = out_q[OUT_W-1:FRAC_W];
  assign div_frac = out_q[FRAC_W-1:0];
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
  parameter int M_W     = 9,
  parameter int FRAC_W  = 16,
  parameter int PHASE_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               running,
  input logic               wrap,
  input logic [PHASE_W-1:0] phase,
  input logic [M_W-1:0]     m_lat,
  input logic [M_W-1:0]     div_int,
  input logic [FRAC_W-1:0]  div_frac
);
  logic [M_W+FRAC_W-1:0] out_q, top_q;
  assign out_q = {div_int, div_frac};
  assign top_q = {m_lat, {FRAC_W{1'b0}}};

  a_r2_idle_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (div_int == m_lat && div_frac == '0));

  a_r3_start_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(running) && m_lat != '0) |-> (phase == '0 && out_q < top_q));

  a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    out_q <= top_q);

  a_r6_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wrap) |=> (running && phase == $past(phase) + PHASE_W'(1)));

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (64'(out_q) * 64'd1000 >= 64'(m_lat) * 64'd65142784));

  a_r8_hold_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wrap) |=> $stable(m_lat));
endmodule

bind spread_tri_gen ssm_checker #(.M_W(M_W), .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .wrap(wrap), .phase(phase),
  .m_lat(m_lat), .div_int(div_int), .div_frac(div_frac)
);

// File: tb/spread_tri_gen_test.sv
module spread_tri_gen_test;
  localparam int S = 328;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spread_en = 1'b0;
  logic [8:0]  nom_m = 9'd192;
  logic [8:0]  div_int;
  logic [15:0] div_frac;

  int checks = 0;
  int errors = 0;

  string tq[$];
  int    iq[$];
  int    fq[$];

  // bench model of the sweep position
  bit b_run = 1'b0;
  int b_ph  = 0;
  int b_m   = 192;

  always #2 clk = ~clk;

  spread_tri_gen uut (
    .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .nom_m(nom_m),
    .div_int(div_int), .div_frac(div_frac)
  );

  task automatic check(input string tag, input int gi, input int gf, input int ei, input int ef);
    checks++;
    if (gi != ei || gf != ef) begin
      errors++;
      $display("FAIL %s: got %0d.%04h expected %0d.%04h", tag, gi, gf, ei, ef);
    end
  endtask

  // drive one cycle of inputs and queue the output expected after the next edge
  task automatic drive(input bit en, input int m, input string tag);
    longint v;
    int tri_n;
    string t;
    @(negedge clk);
    spread_en = en;
    nom_m = 9'(m);
    if (!b_run || b_ph == 511) begin
      b_m = m;
      b_run = en;
      b_ph = 0;
    end else begin
      b_ph++;
    end
    tri_n = !b_run ? 0 : (b_ph < 256 ? 256 - b_ph : b_ph - 256);
    v = (longint'(b_m) << 24) - longint'(b_m) * S * tri_n;
    if (tag != "") t = tag;
    else if (!b_run) t = "R2";
    else if (b_ph == 0) t = "R3 R7";
    else if (b_ph < 256) t = "R4";
    else if (b_ph == 256) t = "R5";
    else t = "R6";
    tq.push_back(t);
    iq.push_back(int'(v >> 24));
    fq.push_back(int'((v >> 8) & 64'hFFFF));
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (iq.size() > 0) begin
      string t;
      int ei, ef;
      t = tq.pop_front();
      ei = iq.pop_front();
      ef = fq.pop_front();
      check(t, int'(div_int), int'(div_frac), ei, ef);
    end
  end

  bit done = 1'b0;
  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(div_int), int'(div_frac), 192, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(div_int), int'(div_frac), 192, 0);
    // idle tracking
    for (int i = 0; i < 3; i++) drive(1'b0, 150, "R2");
    drive(1'b0, 200, "R2");
    // two full sweeps at the default nominal
    for (int i = 0; i < 1024; i++) drive(1'b1, 192, "");
    // new nominal exactly at the boundary, enable held high
    drive(1'b1, 511, "R10");
    for (int i = 0; i < 511; i++) drive(1'b1, 511, "");
    // mid-sweep nominal change must wait for the boundary
    drive(1'b1, 511, "R3");
    for (int i = 0; i < 511; i++) drive(1'b1, 300, "R8");
    drive(1'b1, 100, "R10");
    for (int i = 0; i < 100; i++) drive(1'b1, 100, "");
    // enable dropped mid-sweep: the sweep completes first
    for (int i = 0; i < 411; i++) drive(1'b0, 100, "R9");
    // boundary with enable low and a new nominal
    drive(1'b0, 90, "R9");
    for (int i = 0; i < 3; i++) drive(1'b0, 90, "R2");
    // restart from idle
    drive(1'b1, 90, "R3");
    for (int i = 0; i < 300; i++) drive(1'b1, 90, "");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule